// File: doc/BRIEF.md
# Alternating Two-Input Stream Merger

This block is a dataflow actor that merges two token streams onto one output stream by taking from each input in strict turn. It sits between FIFO channels. Each input is read through a data bus, an empty flag and a pop strobe. The output is written through a data bus, a full flag and a push strobe. Tokens are plain integers with no tag. The input FIFOs are expected to present their head word while not empty (first-word fall-through).

A one-bit turn register decides which input is served next. The block does not arbitrate by availability. When the input whose turn it is has no token, the block waits on it, even if the other input holds data. A transfer completes in one clock cycle: the pop strobe, the push strobe and the output data all appear in the same cycle, so a token moves every cycle when both sides allow it.

Top module: `stream_alt_merge`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, no pop and no push is issued. The first token taken after reset comes from input 0.
- R2: When it is input 0's turn, `in0_empty` is 0 and `out_full` is 0, the block raises `in0_pop` and `out_push` in that same cycle, drives `out_dat` equal to `in0_dat`, and hands the turn to input 1.
- R3: When it is input 1's turn, `in1_empty` is 0 and `out_full` is 0, the block raises `in1_pop` and `out_push` in that same cycle, drives `out_dat` equal to `in1_dat`, and hands the turn to input 0.
- R4: The input that does not hold the turn is never popped, whatever its empty flag says. Pops therefore strictly alternate 0, 1, 0, 1 across the whole run.
- R5: At most one pop strobe is high in any cycle. `out_push` is high exactly in the cycles in which one pop strobe is high.
- R6: While `out_full` is 1, no pop and no push is issued and the turn does not change, so no token is lost or duplicated.
- R7: Each transferred token raises each strobe for exactly one cycle. Back-to-back transfers sustain one token per clock.
- R8: The token width is the parameter `W` (default 16). All `W` bits pass from input to output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_dat | input | W | Head token of input FIFO 0 |
| in0_empty | input | 1 | Input FIFO 0 is empty |
| in0_pop | output | 1 | Pop strobe to input FIFO 0 |
| in1_dat | input | W | Head token of input FIFO 1 |
| in1_empty | input | 1 | Input FIFO 1 is empty |
| in1_pop | output | 1 | Pop strobe to input FIFO 1 |
| out_dat | output | W | Token written to the output FIFO |
| out_full | input | 1 | Output FIFO is full |
| out_push | output | 1 | Push strobe to the output FIFO |

## Verification
The merge is driven with four input patterns:
- Both inputs loaded and no back-pressure. This shows the one-token-per-cycle zig-zag.
- One input loaded while the other is empty. This separates strict turn-taking from availability-based arbitration.
- A periodic full flag on the output. This exposes a turn change or pop that leaks through back-pressure.
- Random fill and random back-pressure. This mixes stalls on both sides.

A behavioural model built on queues predicts every strobe and data word each cycle. At the end, the model compares the drained output order with the expected interleave, including a word with all bits set.

// File: rtl/alt_merge_pkg.sv
package alt_merge_pkg;

    // Which input holds the turn
    typedef enum logic {
        TURN_IN0 = 1'b0,
        TURN_IN1 = 1'b1
    } turn_e;

    // Registered control state
    typedef struct packed {
        turn_e turn;
        logic  live;   // set one cycle after reset release
    } ctrl_st_t;

    localparam int NUM_IN = 2;

endpackage

// File: rtl/alt_merge_ctrl.sv
module alt_merge_ctrl
    import alt_merge_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  in0_empty,
    input  logic  in1_empty,
    input  logic  out_full,
    output turn_e turn,
    output logic  pop0,
    output logic  pop1,
    output logic  fire
);

    ctrl_st_t st_d, st_q;
    logic     head_ok;

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        head_ok   = (st_q.turn == TURN_IN0) ? !in0_empty : !in1_empty;
        fire      = st_q.live && head_ok && !out_full;
        pop0      = fire && (st_q.turn == TURN_IN0);
        pop1      = fire && (st_q.turn == TURN_IN1);
        if (fire) begin
            st_d.turn = (st_q.turn == TURN_IN0) ? TURN_IN1 : TURN_IN0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.turn <= TURN_IN0;
            st_q.live <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign turn = st_q.turn;

endmodule

// File: rtl/alt_merge_mux.sv
module alt_merge_mux
    import alt_merge_pkg::*;
#(
    parameter int W = 16
) (
    input  turn_e          turn,
    input  logic [W-1:0]   in0_dat,
    input  logic [W-1:0]   in1_dat,
    output logic [W-1:0]   out_dat
);

    logic [NUM_IN-1:0][W-1:0] lane;
    logic [W-1:0]             sel_d;

    assign lane[0] = in0_dat;
    assign lane[1] = in1_dat;

    always_comb begin
        sel_d = lane[0];
        for (int i = 0; i < NUM_IN; i++) begin
            if (int'(turn) == i) sel_d = lane[i];
        end
    end

    assign out_dat = sel_d;

endmodule

// File: rtl/stream_alt_merge.sv
module stream_alt_merge
    import alt_merge_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in0_dat,
    input  logic         in0_empty,
    output logic         in0_pop,
    input  logic [W-1:0] in1_dat,
    input  logic         in1_empty,
    output logic         in1_pop,
    output logic [W-1:0] out_dat,
    input  logic         out_full,
    output logic         out_push
);

    turn_e turn;

    alt_merge_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in0_empty (in0_empty),
        .in1_empty (in1_empty),
        .out_full  (out_full),
        .turn      (turn),
        .pop0      (in0_pop),
        .pop1      (in1_pop),
        .fire      (out_push)
    );

    alt_merge_mux #(.W(W)) u_mux (
        .turn    (turn),
        .in0_dat (in0_dat),
        .in1_dat (in1_dat),
        .out_dat (out_dat)
    );

endmodule

// File: rtl/alt_merge_chk.sv
module alt_merge_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] in0_dat,
    input logic         in0_empty,
    input logic         in0_pop,
    input logic [W-1:0] in1_dat,
    input logic         in1_empty,
    input logic         in1_pop,
    input logic [W-1:0] out_dat,
    input logic         out_full,
    input logic         out_push
);

    // 1 when input 1 was served last (or nothing served since reset)
    logic last1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       last1_q <= 1'b1;
        else if (in0_pop) last1_q <= 1'b0;
        else if (in1_pop) last1_q <= 1'b1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> !(out_push || in0_pop || in1_pop));

    assert_no_pop_empty0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in0_empty |-> !in0_pop);

    assert_data0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in0_pop |-> out_dat == in0_dat);

    assert_no_pop_empty1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in1_empty |-> !in1_pop);

    assert_data1_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in1_pop |-> out_dat == in1_dat);

    assert_alternate0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in0_pop |-> last1_q);

    assert_alternate1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in1_pop |-> !last1_q);

    assert_pop_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({in0_pop, in1_pop}) <= 1);

    assert_push_pairs_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_push == (in0_pop || in1_pop));

    assert_hold_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_full |-> !(out_push || in0_pop || in1_pop));

endmodule

bind stream_alt_merge alt_merge_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in0_dat   (in0_dat),
    .in0_empty (in0_empty),
    .in0_pop   (in0_pop),
    .in1_dat   (in1_dat),
    .in1_empty (in1_empty),
    .in1_pop   (in1_pop),
    .out_dat   (out_dat),
    .out_full  (out_full),
    .out_push  (out_push)
);

// File: tb/stream_alt_merge_tb.sv
module stream_alt_merge_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] in0_dat = '0;
    logic         in0_empty = 1'b1;
    logic         in0_pop;
    logic [W-1:0] in1_dat = '0;
    logic         in1_empty = 1'b1;
    logic         in1_pop;
    logic [W-1:0] out_dat;
    logic         out_full = 1'b0;
    logic         out_push;

    always #5 clk = ~clk;

    stream_alt_merge #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in0_dat(in0_dat), .in0_empty(in0_empty), .in0_pop(in0_pop),
        .in1_dat(in1_dat), .in1_empty(in1_empty), .in1_pop(in1_pop),
        .out_dat(out_dat), .out_full(out_full), .out_push(out_push)
    );

    // reference model state
    logic [W-1:0] q0[$];
    logic [W-1:0] q1[$];
    logic [W-1:0] got[$];
    logic [W-1:0] want[$];
    int  m_turn = 0;
    bit  m_live = 0;
    int  checks = 0;
    int  errors = 0;
    bit  done = 0;
    int  seq0 = 0;
    int  seq1 = 0;

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic add0(input logic [W-1:0] v);
        q0.push_back(v);
    endtask

    task automatic add1(input logic [W-1:0] v);
        q1.push_back(v);
    endtask

    task automatic step(input bit rst_v, input bit full_v);
        bit    e0, e1, fire, p0, p1;
        string tag;
        @(negedge clk);
        rst_n     = rst_v;
        out_full  = full_v;
        e0        = (q0.size() == 0);
        e1        = (q1.size() == 0);
        in0_empty = e0;
        in1_empty = e1;
        in0_dat   = e0 ? '0 : q0[0];
        in1_dat   = e1 ? '0 : q1[0];
        if (!rst_v) begin
            m_live = 0;
            m_turn = 0;
        end
        fire = rst_v && m_live && !full_v && ((m_turn == 0) ? !e0 : !e1);
        p0   = fire && (m_turn == 0);
        p1   = fire && (m_turn == 1);
        if (!rst_v || !m_live)                   tag = "R1";
        else if (full_v)                         tag = "R6";
        else if (m_turn == 0 && e0 && !e1)       tag = "R4";
        else if (m_turn == 1 && e1 && !e0)       tag = "R4";
        else if (m_turn == 0)                    tag = "R2";
        else                                     tag = "R3";
        #1;
        chk({tag, " in0_pop"}, W'(in0_pop), W'(p0));
        chk({tag, " in1_pop"}, W'(in1_pop), W'(p1));
        chk({tag, " R5 R7 out_push"}, W'(out_push), W'(fire));
        if (fire) begin
            chk({tag, " out_dat"}, out_dat, p0 ? q0[0] : q1[0]);
            got.push_back(out_dat);
            if (p0) void'(q0.pop_front());
            else    void'(q1.pop_front());
            m_turn = 1 - m_turn;
        end
        m_live = rst_v;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int n;
        // R1: reset with data present on both sides
        for (int i = 0; i < 4; i++) begin
            add0(W'(16'h1000 + seq0)); seq0++;
            add1(W'(16'h8000 + seq1)); seq1++;
        end
        repeat (3) step(1'b0, 1'b0);
        step(1'b1, 1'b0);   // first live cycle: still quiet (R1)
        // R1: first token comes from input 0
        step(1'b1, 1'b0);
        chk("R1 first token from in0", got.size() > 0 ? got[0] : 'x, 16'h1000);
        // R2 R3 R7: back-to-back zig-zag
        repeat (10) step(1'b1, 1'b0);
        // R4: only input 0 loaded; stalls after one take
        for (int i = 0; i < 5; i++) begin add0(W'(16'h1000 + seq0)); seq0++; end
        repeat (6) step(1'b1, 1'b0);
        chk("R4 in0 left waiting", W'(q0.size()), W'(4));
        add1(W'(16'h8000 + seq1)); seq1++;
        add1(16'hFFFF);   // R8 full-width word
        repeat (6) step(1'b1, 1'b0);
        // R6: periodic back-pressure with data on both sides
        for (int i = 0; i < 12; i++) begin
            add0(W'(16'h1000 + seq0)); seq0++;
            add1(W'(16'h8000 + seq1)); seq1++;
        end
        for (int c = 0; c < 40; c++) step(1'b1, (c % 3) != 2);
        // random mix
        for (int c = 0; c < 600; c++) begin
            if ($urandom_range(0, 2) == 0) begin add0(W'(16'h1000 + (seq0 % 4096))); seq0++; end
            if ($urandom_range(0, 2) == 0) begin add1(W'(16'h8000 + (seq1 % 4096))); seq1++; end
            step(1'b1, $urandom_range(0, 3) == 0);
        end
        // drain
        for (int c = 0; c < 200 && (q0.size() != 0 || q1.size() != 0); c++) begin
            if (q0.size() == 0 && q1.size() != 0 && m_turn == 0) break;
            if (q1.size() == 0 && q0.size() != 0 && m_turn == 1) break;
            step(1'b1, 1'b0);
        end
        // R4 R7: order of the output stream is a strict 0/1 interleave
        n = 0;
        for (int i = 0; i < got.size(); i++) begin
            if (((i % 2) == 0) != (got[i][15] == 1'b0)) n++;
        end
        chk("R4 interleave order violations", W'(n), '0);
        // R8: the all-ones word passed intact
        n = 0;
        foreach (got[i]) if (got[i] == 16'hFFFF) n++;
        chk("R8 full-width word seen", W'(n), W'(1));
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule